// File: doc/BRIEF.md
# Multi-queue copy-ring control registers

This block is the control and status register bank of a copy engine that works through rings of descriptors in memory, one ring per hardware queue. Software sets how many queues are live, and gives each live queue a ring base address and a ring length counted in descriptors. The engine reports progress by pulsing a per-queue "descriptor retired" input. The bank then moves that queue's read index one slot forward, wrapping at the ring length, and raises the queue's pending flag. The pending flag drives the queue's interrupt output.

Access is a plain 32-bit register port with a write strobe, a byte address and a combinational read word. Address bits [4:0] select a word inside a 32-byte window. The upper address bits select the window. Window 0 holds the global queue-count word, and window n+1 belongs to queue n. Descriptor fetch, data movement and bus mastering sit outside this block.

Top module: `copyq_csr`

## Requirements
- R1: After reset every readable word returns zero and every interrupt output is low.
- R2: The queue-count word sits at address 0x000. A write stores the written value, clamped to the number of queues built (16 by default), and a read returns the stored count.
- R3: Queue n owns the window starting at (n+1)*0x20. In that window, offset 0x08 is the ring length, which keeps the low 16 bits of a write and reads back zero-extended. Offsets 0x18 and 0x1C are the low and high halves of the ring base and keep all 32 bits. Offsets 0x00, 0x04 and 0x10 read zero and ignore writes. Address bits [1:0] are ignored.
- R4: Offset 0x0C of a queue window is the read index. It reads zero-extended and software writes to it have no effect. On each retire pulse it becomes index+1, or 0 when index+1 is not below the ring length, so a length of 0 or 1 holds it at 0.
- R5: If software shrinks the ring length below the current read index, the next retire pulse sets the index to 0.
- R6: A retire pulse sets the queue's pending flag (bit 0 at offset 0x14) at the same clock edge that moves the index. The queue's interrupt output is high whenever the flag is set and the queue is active.
- R7: A write to offset 0x14 with bit 0 at 0 clears the pending flag. A write with bit 0 at 1 leaves the flag unchanged.
- R8: When a retire pulse and a clearing write reach the same queue in the same cycle, the flag ends set and the index still advances.
- R9: A queue whose number is not below the queue count is inactive. Its window reads zero, it ignores writes and retire pulses, and its interrupt output stays low.
- R10: Global-window offsets other than 0x00, and windows above the last queue, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Write strobe for the register port |
| reg_addr | input | 10 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| retire | input | 16 | Per-queue one-cycle descriptor-retired pulses |
| irq | output | 16 | Per-queue interrupt outputs |

## Verification
The pending flag has two writers. Hardware sets it on a retire pulse and software clears it through offset 0x14, and both can reach one queue in the same cycle. The bench drives a retire pulse and a bit-0-clear write to the same queue on the same clock edge. It then reads back the status word, the read index and the interrupt line, and expects the flag still set and the index advanced by one. Clears that arrive alone and retires that arrive alone are also run, so that a wrong priority shows up in the status word.

// File: rtl/copyq_csr_pkg.sv
package copyq_csr_pkg;

  localparam int unsigned WORD_W = 32;

  // word index (byte offset >> 2) inside a queue window
  localparam logic [2:0] QW_LEN  = 3'd2;
  localparam logic [2:0] QW_RIDX = 3'd3;
  localparam logic [2:0] QW_STAT = 3'd5;
  localparam logic [2:0] QW_BLO  = 3'd6;
  localparam logic [2:0] QW_BHI  = 3'd7;

  // next ring slot: wrap to zero once the incremented index reaches length
  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input logic [31:0] len);
    logic [32:0] inc;
    inc = {1'b0, idx} + 33'd1;
    return (inc >= {1'b0, len}) ? 32'd0 : inc[31:0];
  endfunction

  // clamp a requested queue count to the number built
  function automatic logic [31:0] sat_count(input logic [31:0] req,
                                            input int unsigned lim);
    return (req > 32'(lim)) ? 32'(lim) : req;
  endfunction

endpackage

// File: rtl/copyq_qslot.sv
module copyq_qslot
  import copyq_csr_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [2:0]        wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              retire,
  input  logic [2:0]        rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);

  logic [IDX_W-1:0]  len_q;
  logic [IDX_W-1:0]  ridx_q;
  logic [WORD_W-1:0] base_lo_q;
  logic [WORD_W-1:0] base_hi_q;
  logic              pend_q;

  // named events for the assertions
  logic wr_ok, ret_evt, clr_evt;
  assign wr_ok   = wr_en & active;
  assign ret_evt = retire & active;
  assign clr_evt = wr_ok && (wr_word == QW_STAT) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q     <= '0;
      ridx_q    <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (wr_ok && wr_word == QW_LEN) len_q     <= wr_data[IDX_W-1:0];
      if (wr_ok && wr_word == QW_BLO) base_lo_q <= wr_data;
      if (wr_ok && wr_word == QW_BHI) base_hi_q <= wr_data;
      if (ret_evt) ridx_q <= IDX_W'(ring_next(32'(ridx_q), 32'(len_q)));
      if (ret_evt)      pend_q <= 1'b1;
      else if (clr_evt) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (active) begin
      case (rd_word)
        QW_LEN:  rd_data = 32'(len_q);
        QW_RIDX: rd_data = 32'(ridx_q);
        QW_STAT: rd_data = {31'd0, pend_q};
        QW_BLO:  rd_data = base_lo_q;
        QW_BHI:  rd_data = base_hi_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign irq = pend_q & active;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> (ridx_q == $past(ridx_q) + 1'b1) || (ridx_q == '0)); // R4
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_evt |=> $stable(ridx_q)); // R4
  AST_PEND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> pend_q); // R8
  AST_CLR_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(clr_evt)); // R7
  AST_DARK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(len_q) && $stable(base_lo_q) && $stable(pend_q)); // R9

endmodule

// File: rtl/copyq_rdsel.sv
module copyq_rdsel
  import copyq_csr_pkg::*;
#(
  parameter int NQ    = 16,
  parameter int WIN_W = 5
) (
  input  logic [WIN_W-1:0]           win,
  input  logic [2:0]                 word,
  input  logic [WORD_W-1:0]          global_word,
  input  logic [NQ-1:0][WORD_W-1:0]  q_rdata,
  output logic [WORD_W-1:0]          rdata
);

  always_comb begin
    rdata = '0;
    if (win == '0) begin
      if (word == 3'd0) rdata = global_word;
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (32'(win) == 32'(i + 1)) rdata = q_rdata[i];
      end
    end
  end

endmodule

// File: rtl/copyq_csr.sv
module copyq_csr
  import copyq_csr_pkg::*;
#(
  parameter int NQ     = 16,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NQ-1:0]     retire,
  output logic [NQ-1:0]     irq
);

  localparam int CNT_W = $clog2(NQ + 1);
  localparam int WIN_W = ADDR_W - 5;

  logic [WIN_W-1:0] win;
  logic [2:0]       word;
  logic [1:0]       unused_lsb;
  assign win        = reg_addr[ADDR_W-1:5];
  assign word       = reg_addr[4:2];
  assign unused_lsb = reg_addr[1:0];

  logic [CNT_W-1:0] qcount_q;
  logic             cnt_wr;
  assign cnt_wr = reg_wen && (win == '0) && (word == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)      qcount_q <= '0;
    else if (cnt_wr) qcount_q <= CNT_W'(sat_count(reg_wdata, NQ));
  end

  logic [NQ-1:0][WORD_W-1:0] q_rdata;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic act;
    logic wsel;
    assign act  = 32'(g) < 32'(qcount_q);
    assign wsel = reg_wen && (32'(win) == 32'(g + 1));
    copyq_qslot #(.IDX_W(IDX_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (act),
      .wr_en   (wsel),
      .wr_word (word),
      .wr_data (reg_wdata),
      .retire  (retire[g]),
      .rd_word (word),
      .rd_data (q_rdata[g]),
      .irq     (irq[g])
    );
  end

  copyq_rdsel #(.NQ(NQ), .WIN_W(WIN_W)) u_rdsel (
    .win         (win),
    .word        (word),
    .global_word (32'(qcount_q)),
    .q_rdata     (q_rdata),
    .rdata       (reg_rdata)
  );

  // window that maps to no live queue
  logic win_dark;
  assign win_dark = (win != '0) && (32'(win) > 32'(qcount_q));

  AST_DARK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_dark |-> reg_rdata == '0); // R9
  AST_GLOBAL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win == '0 && word != 3'd0) |-> reg_rdata == '0); // R10
  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> 32'(qcount_q) <= 32'(NQ)); // R2

endmodule

// File: tb/sim_copyq_csr.sv
module sim_copyq_csr;
  localparam int CLK_P = 10;
  localparam int NQ = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NQ-1:0] retire = '0;
  logic [NQ-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  copyq_csr u0 (.clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
                .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .retire(retire), .irq(irq));

  function automatic logic [9:0] qa(input int q, input int off);
    return 10'((q + 1) * 32 + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [9:0] a, input logic [31:0] d,
                     input logic [NQ-1:0] r);
    @(negedge clk);
    reg_wen = w; reg_addr = a; reg_wdata = d; retire = r;
    @(posedge clk); #1;
    reg_wen = 1'b0; retire = '0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic ret(input int q);
    cyc(1'b0, '0, '0, NQ'(1) << q);
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h000, d); chk("R1 qcount", d, 0);
    rd(qa(0, 8), d); chk("R1 q0 len", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(10'h000, 40); rd(10'h000, d); chk("R2 clamp", d, 16);
    wr(10'h000, 3);  rd(10'h000, d); chk("R2 count", d, 3);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(qa(1, 8), 32'h0001_2345); rd(qa(1, 8), d); chk("R3 len low bits", d, 32'h2345);
    wr(qa(1, 24), 32'hDEAD_BEEF); wr(qa(1, 28), 32'h0000_00AB);
    rd(qa(1, 24) + 10'd2, d); chk("R3 base lo", d, 32'hDEAD_BEEF);
    rd(qa(1, 28), d); chk("R3 base hi", d, 32'h0000_00AB);
    wr(qa(1, 4), 32'hFFFF_FFFF); rd(qa(1, 4), d); chk("R3 gap zero", d, 0);
  endtask

  task automatic t_index();
    logic [31:0] d;
    logic [31:0] exp [4] = '{1, 2, 0, 1};
    wr(qa(0, 8), 3);
    for (int i = 0; i < 4; i++) begin
      ret(0); rd(qa(0, 12), d); chk("R4 advance/wrap", d, exp[i]);
    end
    wr(qa(0, 12), 7); rd(qa(0, 12), d); chk("R4 index read-only", d, 1);
  endtask

  task automatic t_shrink();
    logic [31:0] d;
    wr(qa(0, 8), 5);
    ret(0); ret(0); ret(0);
    rd(qa(0, 12), d); chk("R5 pre-shrink", d, 4);
    wr(qa(0, 8), 2); ret(0);
    rd(qa(0, 12), d); chk("R5 shrink wrap", d, 0);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    rd(qa(0, 20), d); chk("R6 pending", d, 1);
    chk("R6 irq", 32'(irq[0]), 1);
    wr(qa(0, 20), 32'hFFFF_FFFF); rd(qa(0, 20), d); chk("R7 set bit keeps", d, 1);
    wr(qa(0, 20), 32'hFFFF_FFFE); rd(qa(0, 20), d); chk("R7 clear", d, 0);
    chk("R7 irq low", 32'(irq[0]), 0);
  endtask

  task automatic t_same();
    logic [31:0] d;
    wr(qa(2, 8), 4);
    cyc(1'b1, qa(2, 20), 32'h0, NQ'(1) << 2);
    rd(qa(2, 20), d); chk("R8 set wins", d, 1);
    rd(qa(2, 12), d); chk("R8 index moved", d, 1);
    chk("R8 irq", 32'(irq[2]), 1);
  endtask

  task automatic t_dark();
    logic [31:0] d;
    wr(qa(5, 8), 9); rd(qa(5, 8), d); chk("R9 dark read", d, 0);
    ret(5); chk("R9 dark irq", 32'(irq[5]), 0);
    wr(10'h000, 16);
    rd(qa(5, 8), d);  chk("R9 write ignored", d, 0);
    rd(qa(5, 12), d); chk("R9 retire ignored", d, 0);
    rd(qa(5, 20), d); chk("R9 no pending", d, 0);
  endtask

  task automatic t_outside();
    logic [31:0] d;
    wr(10'h004, 32'hFF); rd(10'h004, d); chk("R10 global gap", d, 0);
    rd(10'h220, d); chk("R10 window 17", d, 0);
    rd(10'h3E8, d); chk("R10 top window", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset(); t_count(); t_layout(); t_index(); t_shrink();
    t_pend(); t_same(); t_dark(); t_outside();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule